// File: doc/BRIEF.md
# HDLC receiver with address filter

This block sits behind a serial line and turns a bit stream into HDLC frame bytes. Each bit arrives on `bit_i` together with a one-cycle strobe `bit_en_i`. The block finds opening and closing flags and removes the zeros that the sender inserted. It packs the bits into bytes, least significant bit first. It runs the frame check sequence over each frame and, when the filter is on, drops frames that are addressed to another station. Every byte that is accepted goes to the write port of a downstream FIFO. Four status bits travel with each byte so that software can read them along with the data.

The byte stream on the write port contains every byte between the flags, including the two FCS bytes. The last byte of a frame can only be recognised once the closing flag arrives, so each byte is held back by one byte time. When reception is switched off, a packet already under way is still finished before the block goes quiet. A transparent mode skips all framing and delivers raw bytes. In that mode the falling edge of the enable sets the byte boundary.

Top module: `hdlc_rx_filter`

## Requirements
- R1: While reset is held and after it is released, `wr_en_o` stays low until a frame byte or a transparent byte is complete.
- R2: A flag is the bit pattern 0,1,1,1,1,1,1,0. Once the receiver is in sync, the bytes between two flags are written in order, including both FCS bytes, with each byte assembled least significant bit first. Tag bit 0 (first) is set on the first byte written for a frame and tag bit 1 (end of packet) on the last.
- R3: A 0 that follows five consecutive 1s inside a frame is removed from the data.
- R4: The FCS is CRC-16 with reflected polynomial 0x8408 and preset 0xFFFF, taken over the address byte through the second FCS byte. A remainder other than 0xF0B8 sets tag bit 2 (bad FCS) on the end-of-packet byte.
- R5: Tag bit 2 is also set on the end-of-packet byte in two cases: the frame, counting both FCS bytes, has fewer than 4 bytes, or the closing flag does not begin on a byte boundary.
- R6: Seven consecutive 1s inside a frame abort it. The byte being held is written with tag bit 3 (abort) and tag bit 1 set. Nothing more is written until a new flag arrives.
- R7: With `addr_en_i` high, a frame is written only when its first byte equals `addr_i` or the all-call value 0xFF. All other frames produce no write at all.
- R8: With `addr_en_i` low, frames are written whatever their first byte is.
- R9: Dropping `rx_en_i` after a frame's first byte has arrived still lets the whole frame be written, up to and including its end-of-packet byte. While `rx_en_i` is low and no packet is under way, no frame is received.
- R10: Raising `rx_en_i` starts the flag hunt on the very next strobe. A frame whose opening flag starts with the first strobe after the enable is received.
- R11: With `transp_i` high and `rx_en_i` high, every 8 strobes produce one write of the raw bits, least significant bit first, with all tag bits 0. Zeros are not removed, and flags and aborts are not detected.
- R12: In transparent mode, a falling edge of `rx_en_i` resets the byte position to bit 0, and strobes that arrive while `rx_en_i` is low are ignored.
- R13: `wr_en_o` is high only in the cycle right after a clock edge at which `bit_en_i` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial receive data |
| bit_en_i | input | 1 | Strobe: `bit_i` is valid in this cycle |
| rx_en_i | input | 1 | Receiver enable |
| addr_en_i | input | 1 | Address filter enable |
| addr_i | input | 8 | Station address the filter accepts |
| transp_i | input | 1 | Transparent mode select |
| wr_en_o | output | 1 | FIFO write strobe |
| wr_data_o | output | 8 | Byte to write |
| wr_tag_o | output | 4 | Byte status: bit 0 first, bit 1 end of packet, bit 2 bad FCS, bit 3 abort |

## Verification
A write is registered. It appears exactly one cycle after the strobe that completes it: the strobe that finishes the next byte, the last bit of the closing flag, the seventh 1 of an abort, or the eighth raw bit in transparent mode. The bench therefore gaps its strobes by one idle cycle, captures writes on the falling clock edge, and separately checks that every write follows a strobe edge. Each scenario ends with three idle cycles before its captured writes are compared, byte by byte and tag by tag, against a list the bench builds from the frame contents and its own CRC arithmetic.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 16'h8408;
  localparam logic [CRC_W-1:0] CRC_PRESET   = 16'hFFFF;
  localparam logic [CRC_W-1:0] CRC_GOOD     = 16'hF0B8;

  typedef struct packed {
    logic abort;
    logic bad_fcs;
    logic eop;
    logic first;
  } rx_tag_t;
endpackage

// File: rtl/hdlc_rx_bitfront.sv
module hdlc_rx_bitfront #(
  parameter int unsigned STUFF_RUN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic bit_en_i,
  input  logic run_i,
  output logic data_vld_o,
  output logic data_bit_o,
  output logic flag_o,
  output logic abort_o
);
  localparam int unsigned FLAG_RUN = STUFF_RUN + 1;
  localparam int unsigned SAT_RUN  = FLAG_RUN + 1;
  localparam int unsigned RUN_W    = $clog2(SAT_RUN + 1);

  logic [RUN_W-1:0] ones_q;
  logic strobe, stuffed;

  always_comb begin
    strobe     = run_i && bit_en_i;
    flag_o     = strobe && !bit_i && (ones_q == RUN_W'(FLAG_RUN));
    abort_o    = strobe &&  bit_i && (ones_q == RUN_W'(FLAG_RUN));
    stuffed    = strobe && !bit_i && (ones_q == RUN_W'(STUFF_RUN));
    data_vld_o = strobe && !flag_o && !abort_o && !stuffed;
    data_bit_o = bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q <= '0;
    end else if (!run_i) begin
      ones_q <= '0;
    end else if (bit_en_i) begin
      if (!bit_i)                            ones_q <= '0;
      else if (ones_q != RUN_W'(SAT_RUN))    ones_q <= ones_q + 1'b1;
    end
  end

  // R2
  events_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({data_vld_o, flag_o, abort_o}));
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
  import hdlc_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] crc_q, crc_nxt;

  always_comb begin
    crc_nxt = crc_q ^ {{(CRC_W-BYTE_W){1'b0}}, byte_i};
    for (int i = 0; i < BYTE_W; i++)
      crc_nxt = crc_nxt[0] ? ((crc_nxt >> 1) ^ CRC_POLY_REV) : (crc_nxt >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_PRESET;
    else if (init_i) crc_q <= CRC_PRESET;
    else if (upd_i)  crc_q <= crc_nxt;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/hdlc_rx_frame.sv
module hdlc_rx_frame
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned MIN_LEN  = 4,
  parameter logic [7:0]  ALL_CALL = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_en_i,
  input  logic              rx_en_i,
  input  logic              run_i,
  input  logic              addr_en_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic              transp_i,
  input  logic              d_vld_i,
  input  logic              d_bit_i,
  input  logic              flag_i,
  input  logic              abort_i,
  input  logic [CRC_W-1:0]  crc_i,
  output logic              crc_init_o,
  output logic              crc_upd_o,
  output logic [BYTE_W-1:0] crc_byte_o,
  output logic              in_pkt_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output rx_tag_t           wr_tag_o
);
  localparam int unsigned BIT_W = $clog2(BYTE_W);
  localparam int unsigned CNT_W = $clog2(MIN_LEN + 1);

  typedef enum logic {ST_HUNT, ST_FRAME} st_e;

  st_e               state_q;
  logic [BYTE_W-1:0] sr_q, sr_nxt, pend_q;
  logic [BIT_W-1:0]  bitcnt_q;
  logic [CNT_W-1:0]  nbytes_q;
  logic              pend_vld_q, pend_first_q, discard_q, rx_en_q;
  logic              last_bit, in_frame, byte_done, first_nxt, addr_ok, keep, bad_end, t_fall;
  logic              wr_en_q;
  logic [BYTE_W-1:0] wr_data_q;
  rx_tag_t           wr_tag_q;

  always_comb begin
    sr_nxt     = {(transp_i ? bit_i : d_bit_i), sr_q[BYTE_W-1:1]};
    last_bit   = bitcnt_q == BIT_W'(BYTE_W-1);
    in_frame   = state_q == ST_FRAME;
    byte_done  = !transp_i && run_i && in_frame && d_vld_i && last_bit;
    first_nxt  = nbytes_q == '0;
    addr_ok    = !addr_en_i || (sr_nxt == addr_i) || (sr_nxt == ALL_CALL);
    keep       = in_frame && pend_vld_q && !discard_q;
    bad_end    = (crc_i != CRC_GOOD) || (nbytes_q < CNT_W'(MIN_LEN)) || !last_bit;
    t_fall     = rx_en_q && !rx_en_i;
    crc_init_o = flag_i;
    crc_upd_o  = byte_done;
    crc_byte_o = sr_nxt;
    in_pkt_o   = in_frame && (nbytes_q != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_HUNT;
      sr_q         <= '0;
      pend_q       <= '0;
      bitcnt_q     <= '0;
      nbytes_q     <= '0;
      pend_vld_q   <= 1'b0;
      pend_first_q <= 1'b0;
      discard_q    <= 1'b0;
      rx_en_q      <= 1'b0;
      wr_en_q      <= 1'b0;
      wr_data_q    <= '0;
      wr_tag_q     <= '0;
    end else begin
      wr_en_q <= 1'b0;
      rx_en_q <= rx_en_i;
      if (transp_i) begin
        state_q    <= ST_HUNT;
        pend_vld_q <= 1'b0;
        nbytes_q   <= '0;
        if (t_fall) begin
          bitcnt_q <= '0;
        end else if (rx_en_i && bit_en_i) begin
          sr_q     <= sr_nxt;
          bitcnt_q <= bitcnt_q + 1'b1;
          if (last_bit) begin
            wr_en_q   <= 1'b1;
            wr_data_q <= sr_nxt;
            wr_tag_q  <= '0;
          end
        end
      end else if (!run_i) begin
        state_q    <= ST_HUNT;
        pend_vld_q <= 1'b0;
        nbytes_q   <= '0;
      end else if (flag_i) begin
        if (keep) begin
          wr_en_q          <= 1'b1;
          wr_data_q        <= pend_q;
          wr_tag_q.first   <= pend_first_q;
          wr_tag_q.eop     <= 1'b1;
          wr_tag_q.bad_fcs <= bad_end;
          wr_tag_q.abort   <= 1'b0;
        end
        state_q    <= ST_FRAME;
        bitcnt_q   <= '0;
        nbytes_q   <= '0;
        pend_vld_q <= 1'b0;
        discard_q  <= 1'b0;
      end else if (abort_i) begin
        if (keep) begin
          wr_en_q          <= 1'b1;
          wr_data_q        <= pend_q;
          wr_tag_q.first   <= pend_first_q;
          wr_tag_q.eop     <= 1'b1;
          wr_tag_q.bad_fcs <= 1'b0;
          wr_tag_q.abort   <= 1'b1;
        end
        state_q    <= ST_HUNT;
        nbytes_q   <= '0;
        pend_vld_q <= 1'b0;
      end else if (d_vld_i && in_frame) begin
        sr_q     <= sr_nxt;
        bitcnt_q <= bitcnt_q + 1'b1;
        if (last_bit) begin
          if (keep) begin
            wr_en_q   <= 1'b1;
            wr_data_q <= pend_q;
            wr_tag_q  <= '{abort: 1'b0, bad_fcs: 1'b0, eop: 1'b0, first: pend_first_q};
          end
          pend_q       <= sr_nxt;
          pend_vld_q   <= 1'b1;
          pend_first_q <= first_nxt;
          if (first_nxt) discard_q <= !addr_ok;
          if (nbytes_q < CNT_W'(MIN_LEN)) nbytes_q <= nbytes_q + 1'b1;
        end
      end
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_data_o = wr_data_q;
  assign wr_tag_o  = wr_tag_q;

  // R6
  abort_ends_pkt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_q && wr_tag_q.abort) |-> wr_tag_q.eop);

  // R7
  addr_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_q && wr_tag_q.first && addr_en_i && !transp_i) |->
      ((wr_data_q == addr_i) || (wr_data_q == ALL_CALL)));

  // R11
  transp_untagged_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_q && transp_i && $past(transp_i)) |-> (wr_tag_q == '0));

  // R12
  transp_realign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (transp_i && $fell(rx_en_i)) |=> !wr_en_q);
endmodule

// File: rtl/hdlc_rx_filter.sv
module hdlc_rx_filter
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned STUFF_RUN = 5,
  parameter int unsigned MIN_LEN   = 4,
  parameter logic [7:0]  ALL_CALL  = 8'hFF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       bit_en_i,
  input  logic       rx_en_i,
  input  logic       addr_en_i,
  input  logic [7:0] addr_i,
  input  logic       transp_i,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o,
  output logic [3:0] wr_tag_o
);
  logic              run, in_pkt;
  logic              d_vld, d_bit, flag, abort;
  logic              crc_init, crc_upd;
  logic [BYTE_W-1:0] crc_byte;
  logic [CRC_W-1:0]  crc;
  rx_tag_t           tag;

  // keep running until the packet under way is finished
  assign run = (rx_en_i || in_pkt) && !transp_i;

  hdlc_rx_bitfront #(.STUFF_RUN(STUFF_RUN)) i_front (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_i      (bit_i),
    .bit_en_i   (bit_en_i),
    .run_i      (run),
    .data_vld_o (d_vld),
    .data_bit_o (d_bit),
    .flag_o     (flag),
    .abort_o    (abort)
  );

  hdlc_rx_crc i_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (crc_init),
    .upd_i  (crc_upd),
    .byte_i (crc_byte),
    .crc_o  (crc)
  );

  hdlc_rx_frame #(.MIN_LEN(MIN_LEN), .ALL_CALL(ALL_CALL)) i_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_i      (bit_i),
    .bit_en_i   (bit_en_i),
    .rx_en_i    (rx_en_i),
    .run_i      (run),
    .addr_en_i  (addr_en_i),
    .addr_i     (addr_i),
    .transp_i   (transp_i),
    .d_vld_i    (d_vld),
    .d_bit_i    (d_bit),
    .flag_i     (flag),
    .abort_i    (abort),
    .crc_i      (crc),
    .crc_init_o (crc_init),
    .crc_upd_o  (crc_upd),
    .crc_byte_o (crc_byte),
    .in_pkt_o   (in_pkt),
    .wr_en_o    (wr_en_o),
    .wr_data_o  (wr_data_o),
    .wr_tag_o   (tag)
  );

  assign wr_tag_o = tag;

  // R13
  write_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(bit_en_i));
endmodule

// File: tb/test_hdlc_rx_filter.sv
module test_hdlc_rx_filter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b1;
  logic       bit_en_i = 1'b0;
  logic       rx_en_i = 1'b0;
  logic       addr_en_i = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic       transp_i = 1'b0;
  logic       wr_en_o;
  logic [7:0] wr_data_o;
  logic [3:0] wr_tag_o;

  localparam logic [3:0] T_FIRST = 4'h1, T_EOP = 4'h2, T_BAD = 4'h4, T_ABORT = 4'h8;

  hdlc_rx_filter i_hdlc_rx_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .bit_en_i(bit_en_i),
    .rx_en_i(rx_en_i), .addr_en_i(addr_en_i), .addr_i(addr_i), .transp_i(transp_i),
    .wr_en_o(wr_en_o), .wr_data_o(wr_data_o), .wr_tag_o(wr_tag_o)
  );

  always #5 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  logic sbits [0:4095];
  int nb = 0, ones_run = 0;
  logic [7:0] fb [0:15];
  int fn = 0;
  logic [7:0] exp_d [0:1023];
  logic [3:0] exp_t [0:1023];
  int nexp = 0;
  logic [7:0] obs_d [0:4095];
  logic [3:0] obs_t [0:4095];
  int nobs = 0, obs_base = 0, r13_bad = 0;
  logic en_seen = 1'b0;
  bit done = 0;

  always @(posedge clk_i) en_seen <= bit_en_i;

  always @(negedge clk_i) begin
    if (rst_ni && wr_en_o && nobs < 4096) begin
      obs_d[nobs] = wr_data_o;
      obs_t[nobs] = wr_tag_o;
      if (!en_seen) r13_bad++;
      nobs++;
    end
  end

  task automatic chk(input logic ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] crc_add(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic put_raw(input logic b);
    sbits[nb] = b; nb++; ones_run = 0;
  endtask

  task automatic put_dbit(input logic b);
    sbits[nb] = b; nb++;
    if (b) begin
      ones_run++;
      if (ones_run == 5) begin sbits[nb] = 1'b0; nb++; ones_run = 0; end
    end else ones_run = 0;
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_dbit(v[i]);
  endtask

  task automatic put_flag();
    put_raw(1'b0);
    for (int i = 0; i < 6; i++) put_raw(1'b1);
    put_raw(1'b0);
  endtask

  task automatic prep(input int n, input logic with_fcs, input logic corrupt);
    logic [15:0] c;
    fn = n;
    if (with_fcs) begin
      c = 16'hFFFF;
      for (int i = 0; i < n; i++) c = crc_add(c, fb[i]);
      c = ~c;
      fb[n] = c[7:0]; fb[n+1] = c[15:8];
      fn = n + 2;
    end
    if (corrupt) fb[1] = fb[1] ^ 8'h10;
  endtask

  task automatic emit_body();
    for (int i = 0; i < fn; i++) put_byte(fb[i]);
  endtask

  task automatic send_frame();
    put_flag(); emit_body(); put_flag();
  endtask

  task automatic add_exp(input logic [7:0] d, input logic [3:0] t);
    exp_d[nexp] = d; exp_t[nexp] = t; nexp++;
  endtask

  task automatic expect_frame(input logic bad);
    logic [3:0] t;
    for (int i = 0; i < fn; i++) begin
      t = (i == 0) ? T_FIRST : 4'h0;
      if (i == fn - 1) t = t | T_EOP | (bad ? T_BAD : 4'h0);
      add_exp(fb[i], t);
    end
  endtask

  task automatic play(input int dis_at);
    for (int i = 0; i < nb; i++) begin
      if (i == dis_at) rx_en_i = 1'b0;
      @(negedge clk_i);
      bit_i = sbits[i];
      bit_en_i = 1'b1;
      @(negedge clk_i);
      bit_en_i = 1'b0;
    end
    nb = 0;
    ones_run = 0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic compare(input string req);
    int n;
    n = nobs - obs_base;
    chk(n == nexp, req, "write count", n, nexp);
    for (int k = 0; k < nexp && k < n; k++)
      chk({obs_t[obs_base+k], obs_d[obs_base+k]} == {exp_t[k], exp_d[k]}, req,
          $sformatf("tag/byte %0d", k), {obs_t[obs_base+k], obs_d[obs_base+k]}, {exp_t[k], exp_d[k]});
    obs_base = nobs;
    nexp = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk(wr_en_o == 1'b0, "R1", "wr_en in reset", wr_en_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(wr_en_o == 1'b0, "R1", "wr_en after reset", wr_en_o, 0);

    // R10: first strobe after enable starts the hunt
    rx_en_i = 1'b1;
    fb[0] = 8'h44; fb[1] = 8'h13; fb[2] = 8'hC2;
    prep(3, 1'b1, 1'b0); send_frame(); expect_frame(1'b0);
    play(-1); compare("R10");

    // R2 R3 R4: idle ones, then a frame that needs bit stuffing
    for (int i = 0; i < 10; i++) put_raw(1'b1);
    fb[0] = 8'h12; fb[1] = 8'h1F; fb[2] = 8'hFF; fb[3] = 8'h7E; fb[4] = 8'hF8; fb[5] = 8'h3E;
    prep(6, 1'b1, 1'b0); send_frame(); expect_frame(1'b0);
    play(-1); compare("R2 R3 R4");

    // R5 R4: sweep payload lengths, FCS good; total below 4 bytes is bad
    for (int n = 1; n <= 9; n++) begin
      for (int i = 0; i < n; i++) fb[i] = 8'((n * 37 + i * 91 + 5) & 255);
      prep(n, 1'b1, 1'b0); send_frame(); expect_frame((n + 2) < 4);
      play(-1);
    end
    compare("R5 R4 length sweep");
    for (int n = 1; n <= 4; n++) begin
      for (int i = 0; i < n; i++) fb[i] = 8'((n * 53 + i * 29 + 1) & 255);
      prep(n, 1'b0, 1'b0); send_frame(); expect_frame(1'b1);
      play(-1);
    end
    compare("R5 short frames");

    // R4: corrupted byte
    fb[0] = 8'hA0; fb[1] = 8'h55; fb[2] = 8'h0F;
    prep(3, 1'b1, 1'b1); send_frame(); expect_frame(1'b1);
    play(-1); compare("R4 bad fcs");

    // R5: closing flag three bits off the byte boundary
    fb[0] = 8'h21; fb[1] = 8'h66;
    prep(2, 1'b1, 1'b0);
    put_flag(); emit_body();
    for (int i = 0; i < 3; i++) put_dbit(1'b0);
    put_flag();
    add_exp(fb[0], T_FIRST); add_exp(fb[1], 4'h0); add_exp(fb[2], 4'h0); add_exp(fb[3], 4'h0);
    add_exp(8'hF0, T_EOP | T_BAD);
    play(-1); compare("R5 misaligned");

    // R6: abort, then resync on a new flag
    put_flag(); put_byte(8'h21); put_byte(8'h03);
    for (int i = 0; i < 7; i++) put_raw(1'b1);
    put_raw(1'b0);
    add_exp(8'h21, T_FIRST); add_exp(8'h03, T_EOP | T_ABORT);
    fb[0] = 8'h09; fb[1] = 8'hB4;
    prep(2, 1'b1, 1'b0); send_frame(); expect_frame(1'b0);
    play(-1); compare("R6");

    // R7: all 256 addresses through the filter
    addr_en_i = 1'b1; addr_i = 8'h5A;
    for (int a = 0; a < 256; a++) begin
      fb[0] = 8'(a); fb[1] = 8'(a) ^ 8'h3C;
      prep(2, 1'b1, 1'b0); send_frame();
      if (a == 8'h5A || a == 8'hFF) expect_frame(1'b0);
      play(-1);
    end
    compare("R7 address sweep");

    // R8: filter off passes a foreign address
    addr_en_i = 1'b0;
    fb[0] = 8'h33; fb[1] = 8'h01;
    prep(2, 1'b1, 1'b0); send_frame(); expect_frame(1'b0);
    play(-1); compare("R8");

    // R9: disable in mid packet, then no reception while disabled
    fb[0] = 8'h71; fb[1] = 8'h02; fb[2] = 8'h90; fb[3] = 8'h18;
    prep(4, 1'b1, 1'b0); send_frame(); expect_frame(1'b0);
    play(28); compare("R9 finish packet");
    fb[0] = 8'h72; fb[1] = 8'h05;
    prep(2, 1'b1, 1'b0); send_frame();
    play(-1); compare("R9 disabled idle");

    // R10: re-enable and receive straight away
    rx_en_i = 1'b1;
    fb[0] = 8'h73; fb[1] = 8'h06;
    prep(2, 1'b1, 1'b0); send_frame(); expect_frame(1'b0);
    play(-1); compare("R10 re-enable");

    // R11: transparent bytes, no framing
    transp_i = 1'b1;
    @(negedge clk_i); rx_en_i = 1'b0;
    repeat (2) @(negedge clk_i); rx_en_i = 1'b1;
    fb[0] = 8'h7E; fb[1] = 8'hFF; fb[2] = 8'h1F; fb[3] = 8'h00; fb[4] = 8'hA5; fb[5] = 8'hFE;
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 8; i++) put_raw(fb[k][i]);
      add_exp(fb[k], 4'h0);
    end
    play(-1); compare("R11");

    // R12: stray bits, realign on falling enable, ignore strobes while low
    put_raw(1'b1); put_raw(1'b0); put_raw(1'b1);
    play(-1);
    rx_en_i = 1'b0;
    for (int i = 0; i < 5; i++) put_raw(1'b1);
    play(-1);
    rx_en_i = 1'b1;
    for (int i = 0; i < 8; i++) put_raw(8'h3C >> i);
    add_exp(8'h3C, 4'h0);
    play(-1); compare("R12");

    // R13: every write followed a strobe edge
    chk(r13_bad == 0, "R13", "writes without strobe", r13_bad, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule